// File: doc/BRIEF.md
# SRAM Pattern Test Sequencer

This block is a built-in self-test engine for an external static RAM. It sits in front of a memory controller that accepts one access per cycle: a write completes in the cycle it is requested, and a read answers with a valid strobe after one or more cycles. The sequencer makes five complete passes over the address space. Each pass first writes one pattern to every location in ascending order and then reads every location back, again in ascending order, comparing each word with the value it should hold.

The five patterns expose different faults. Solid ones and solid zeros find bits stuck at one level. The two alternating patterns (bit 0 set, then bit 0 clear) drive each data line against its neighbour, which shows shorts between adjacent lines. The final pass stores each location's own address, which shows address lines that are open or shorted, because such faults make two locations alias each other.

The result is a single sticky good bit and a done flag. These can drive an indicator LED directly or feed a small serial reporter. The test starts by itself when reset is released, and a start pulse runs it again from the beginning.

Top module: `sram_bist_seq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, done_o is 0, good_o is 1 and busy_o is 1. The test begins with no other input: the first request after reset is a write of the all-ones pattern to address 0.
- R2: The patterns run in this fixed order: index 0 is all ones, 1 is all zeros, 2 is alternating with bit 0 set (0x5555 at 16 bits), 3 is alternating with bit 0 clear (0xAAAA at 16 bits), and 4 is the address itself, zero-extended, or cut to its low DATA_W bits when the address is wider. Within each pattern, the writes and then the reads visit addresses 0 to 2^ADDR_W-1 in ascending order.
- R3: A write pass issues one write on every cycle (mem_req_o=1, mem_we_o=1), with mem_wdata_o carrying the pattern value for mem_addr_o. A pass takes exactly 2^ADDR_W cycles.
- R4: Each read is a single request cycle (mem_req_o=1, mem_we_o=0). No further request is made until mem_rvalid_i is seen, and mem_rdata_i is compared in that cycle. A mem_rvalid_i that arrives while no read is outstanding is ignored.
- R5: A compare that does not match clears good_o from the next cycle onward. good_o stays 0 until start_i or reset, even if all later compares match.
- R6: After the last read of pattern 4, done_o goes to 1 and busy_o goes to 0. From then on no memory request is made, and this state holds until start_i.
- R7: start_i has priority in every state. In the cycle after it is sampled, good_o is 1, done_o is 0, and a write of all ones to address 0 is being requested.
- R8: With a read answer latency of L cycles, done_o rises 5·2^ADDR_W·(2+L) cycles after the run starts. A mismatch at address a of pattern p clears good_o after p·2^ADDR_W·(2+L) + 2^ADDR_W + (a+1)·(1+L) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart the whole test sequence |
| mem_req_o | output | 1 | Memory access request this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | DATA_W | Write data (expected data during reads) |
| mem_rvalid_i | input | 1 | Read data valid strobe |
| mem_rdata_i | input | DATA_W | Read data |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test sequence finished |
| good_o | output | 1 | No mismatch seen since start |

## Verification
The hardest cases to reach from the ports are failures that belong to one pattern only, because a single stuck bit is found by the very first pass. To reach them, the bench's memory model injects three kinds of fault. A stuck data bit should be caught in the first verify pass. A bridge that forces bit 1 high whenever bit 0 is written high passes both solid patterns and should fail only in the alternating pass. A dropped top address line passes every constant pattern and should fail only in the address pass. The cycle at which good_o falls therefore confirms both the order of the patterns and the read timing. A further run gives the model a three-cycle read latency and pulses the valid strobe with wrong data while no read is outstanding. That run must still end good, and in exactly the expected number of cycles.

// File: rtl/sram_bist_pkg.sv
package sram_bist_pkg;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_WRITE    = 2'd0,
        PH_RD_ISSUE = 2'd1,
        PH_RD_WAIT  = 2'd2,
        PH_DONE     = 2'd3
    } bist_phase_e;

    // Test patterns; the encoding is also the run order
    typedef enum logic [2:0] {
        PAT_ONES   = 3'd0,
        PAT_ZEROS  = 3'd1,
        PAT_ALT_LO = 3'd2,
        PAT_ALT_HI = 3'd3,
        PAT_ADDR   = 3'd4
    } bist_pat_e;

endpackage

// File: rtl/sram_bist_patgen.sv
module sram_bist_patgen
    import sram_bist_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  bist_pat_e          pat_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [DATA_W-1:0]  data_o
);

    logic [DATA_W-1:0] alt_lo;
    logic [DATA_W-1:0] addr_pat;

    // Alternating word with bit 0 set
    for (genvar b = 0; b < DATA_W; b++) begin : g_alt
        assign alt_lo[b] = ((b % 2) == 0) ? 1'b1 : 1'b0;
    end

    // Address pattern: truncate or zero-extend to the data width
    if (ADDR_W >= DATA_W) begin : g_addr_cut
        assign addr_pat = addr_i[DATA_W-1:0];
    end else begin : g_addr_ext
        assign addr_pat = {{(DATA_W-ADDR_W){1'b0}}, addr_i};
    end

    always_comb begin
        case (pat_i)
            PAT_ONES:   data_o = '1;
            PAT_ZEROS:  data_o = '0;
            PAT_ALT_LO: data_o = alt_lo;
            PAT_ALT_HI: data_o = ~alt_lo;
            PAT_ADDR:   data_o = addr_pat;
            default:    data_o = '0;
        endcase
    end

endmodule

// File: rtl/sram_bist_cmp.sv
module sram_bist_cmp #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              valid_i,
    input  logic [DATA_W-1:0] got_i,
    input  logic [DATA_W-1:0] exp_i,
    output logic              mismatch_o
);

    logic [DATA_W-1:0] diff;

    assign diff       = got_i ^ exp_i;
    assign mismatch_o = valid_i & (|diff);

endmodule

// File: rtl/sram_bist_seq.sv
module sram_bist_seq
    import sram_bist_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              good_o
);

    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    typedef struct packed {
        bist_phase_e       phase;
        bist_pat_e         pat;
        logic [ADDR_W-1:0] addr;
        logic              good;
    } seq_state_t;

    localparam seq_state_t SEQ_INIT = '{
        phase: PH_WRITE,
        pat:   PAT_ONES,
        addr:  '0,
        good:  1'b1
    };

    seq_state_t        s_d, s_q;
    logic [DATA_W-1:0] exp_data;
    logic              cmp_valid;
    logic              mismatch;
    logic              at_last;

    sram_bist_patgen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_patgen (
        .pat_i  (s_q.pat),
        .addr_i (s_q.addr),
        .data_o (exp_data)
    );

    assign cmp_valid = mem_rvalid_i && (s_q.phase == PH_RD_WAIT);

    sram_bist_cmp #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .valid_i    (cmp_valid),
        .got_i      (mem_rdata_i),
        .exp_i      (exp_data),
        .mismatch_o (mismatch)
    );

    assign at_last = (s_q.addr == ADDR_LAST);

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_WRITE: begin
                if (at_last) begin
                    s_d.addr  = '0;
                    s_d.phase = PH_RD_ISSUE;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                end
            end
            PH_RD_ISSUE: begin
                s_d.phase = PH_RD_WAIT;
            end
            PH_RD_WAIT: begin
                if (cmp_valid) begin
                    if (mismatch) begin
                        s_d.good = 1'b0;
                    end
                    if (at_last) begin
                        s_d.addr = '0;
                        if (s_q.pat == PAT_ADDR) begin
                            s_d.phase = PH_DONE;
                        end else begin
                            s_d.pat   = bist_pat_e'(s_q.pat + 3'd1);
                            s_d.phase = PH_WRITE;
                        end
                    end else begin
                        s_d.addr  = s_q.addr + 1'b1;
                        s_d.phase = PH_RD_ISSUE;
                    end
                end
            end
            PH_DONE: begin
                s_d = s_q;
            end
            default: begin
                s_d.phase = PH_DONE;
            end
        endcase
        if (start_i) begin
            s_d = SEQ_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_o   = (s_q.phase == PH_WRITE) || (s_q.phase == PH_RD_ISSUE);
    assign mem_we_o    = (s_q.phase == PH_WRITE);
    assign mem_addr_o  = s_q.addr;
    assign mem_wdata_o = exp_data;
    assign busy_o      = (s_q.phase != PH_DONE);
    assign done_o      = (s_q.phase == PH_DONE);
    assign good_o      = s_q.good;

endmodule

// File: rtl/sram_bist_chk.sv
module sram_bist_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              done_o,
    input logic              good_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    // R5
    good_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!good_o && !start_i) |=> !good_o);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && !mem_req_o));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (good_o && !done_o && mem_req_o && mem_we_o && (mem_addr_o == '0)));

    // R4
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && !start_i) |=> !mem_req_o);

    // R3
    write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && !start_i && (mem_addr_o != TOP_ADDR)) |=>
        (mem_req_o && mem_we_o && (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))));

endmodule

bind sram_bist_seq sram_bist_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .done_o     (done_o),
    .good_o     (good_o)
);

// File: tb/sim_sram_bist_seq.sv
`timescale 1ns/1ps
module sim_sram_bist_seq;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic          mem_rvalid_i;
    logic [DW-1:0] mem_rdata_i;
    logic          busy_o, done_o, good_o;

    always #5 clk = ~clk;

    sram_bist_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .good_o(good_o)
    );

    // ---------------- memory model with fault injection ----------------
    int            lat = 1;
    bit            spur = 1'b0;
    bit            bridge = 1'b0;
    logic [DW-1:0] and_m = '1;
    logic [AW-1:0] amask = '1;
    logic [DW-1:0] mem [0:N-1];
    logic          v [0:3];
    logic [DW-1:0] d [0:3];
    logic          outstanding;

    function automatic logic [DW-1:0] faulty(input logic [DW-1:0] w);
        logic [DW-1:0] s;
        s = w & and_m;
        if (bridge && w[0]) s[1] = 1'b1;
        return s;
    endfunction

    initial for (int i = 0; i < 4; i++) begin v[i] = 1'b0; d[i] = '0; end

    always @(posedge clk) begin
        if (rst_n && mem_req_o && mem_we_o) mem[mem_addr_o & amask] <= faulty(mem_wdata_o);
        v[0] <= rst_n && mem_req_o && !mem_we_o;
        d[0] <= mem[mem_addr_o & amask];
        for (int i = 1; i < 4; i++) begin v[i] <= v[i-1]; d[i] <= d[i-1]; end
    end

    always_comb begin
        outstanding = 1'b0;
        for (int i = 0; i < 4; i++) if (i < lat && v[i]) outstanding = 1'b1;
        if (v[lat-1]) begin
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = d[lat-1];
        end else begin
            mem_rvalid_i = spur && !outstanding;
            mem_rdata_i  = 16'h1234;
        end
    end

    // ---------------- access order monitor ----------------
    int wr_n = 0, rd_n = 0, wr_err = 0, rd_err = 0;
    int wr_base = 0, rd_base = 0, wr_err_base = 0, rd_err_base = 0;

    function automatic logic [DW-1:0] exp_data(input int pat, input int addr);
        case (pat)
            0:       return 16'hFFFF;
            1:       return 16'h0000;
            2:       return 16'h5555;
            3:       return 16'hAAAA;
            default: return DW'(addr);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst_n && mem_req_o) begin
            if (mem_we_o) begin
                if (mem_addr_o != AW'((wr_n - wr_base) % N) ||
                    mem_wdata_o != exp_data((wr_n - wr_base) / N, (wr_n - wr_base) % N))
                    wr_err++;
                wr_n++;
            end else begin
                if (mem_addr_o != AW'((rd_n - rd_base) % N)) rd_err++;
                rd_n++;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic mark_base();
        wr_base = wr_n; rd_base = rd_n; wr_err_base = wr_err; rd_err_base = rd_err;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        mark_base();
        chk("R7 good after start", good_o, 1);
        chk("R7 done after start", done_o, 0);
        chk("R7 first write addr", (mem_req_o && mem_we_o && mem_addr_o == 0) ? 1 : 0, 1);
    endtask

    task automatic wait_done(output int done_cnt, output int fall_cnt);
        done_cnt = -1; fall_cnt = -1;
        for (int c = 1; c <= 20000; c++) begin
            @(posedge clk); #1;
            if (!good_o && fall_cnt < 0) fall_cnt = c;
            if (done_o) begin done_cnt = c; break; end
        end
    endtask

    task automatic check_trace(input string tag);
        chk({tag, " R2 R3 write order/data errors"}, wr_err - wr_err_base, 0);
        chk({tag, " R3 write count"}, wr_n - wr_base, 5 * N);
        chk({tag, " R2 R4 read order errors"}, rd_err - rd_err_base, 0);
        chk({tag, " R4 read count"}, rd_n - rd_base, 5 * N);
    endtask

    task automatic t_reset_clean();
        int dc, fc, reqs;
        rst_n = 1'b0; lat = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset done", done_o, 0);
        chk("R1 reset good", good_o, 1);
        chk("R1 reset busy", busy_o, 1);
        @(negedge clk) rst_n = 1'b1;
        mark_base();
        wait_done(dc, fc);
        chk("R8 clean L=1 done cycle", dc, 5 * N * 3);
        chk("R5 clean good never fell", fc, -1);
        chk("R6 busy low at done", busy_o, 0);
        check_trace("clean");
        reqs = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (mem_req_o) reqs++;
            if (!done_o) reqs += 100;
        end
        chk("R6 idle after done", reqs, 0);
    endtask

    task automatic t_stuck_bit();
        int dc, fc;
        and_m = 16'hFFFE;
        pulse_start();
        wait_done(dc, fc);
        chk("R5 R8 stuck bit fall cycle", fc, N + 2);
        chk("R5 stuck bit good sticky at done", good_o, 0);
        chk("R8 stuck run length", dc, 5 * N * 3);
        and_m = '1;
    endtask

    task automatic t_bridge();
        int dc, fc;
        bridge = 1'b1;
        pulse_start();
        wait_done(dc, fc);
        chk("R2 R8 bridge fails only in alternating pass", fc, 2 * N * 3 + N + 2);
        chk("R5 bridge good at done", good_o, 0);
        bridge = 1'b0;
    endtask

    task automatic t_alias();
        int dc, fc;
        amask = 6'h1F;
        pulse_start();
        wait_done(dc, fc);
        chk("R2 R8 alias fails only in address pass", fc, 4 * N * 3 + N + 2);
        chk("R5 alias good at done", good_o, 0);
        amask = '1;
    endtask

    task automatic t_latency_spur();
        int dc, fc;
        lat = 3; spur = 1'b1;
        pulse_start();
        wait_done(dc, fc);
        chk("R4 R8 L=3 with stray valid done cycle", dc, 5 * N * 5);
        chk("R4 stray valid ignored good", good_o, 1);
        check_trace("latency");
        lat = 1; spur = 1'b0;
    endtask

    task automatic t_restart_midrun();
        int dc, fc;
        pulse_start();
        repeat (500) @(posedge clk);
        #1 chk("R7 mid-run not done", done_o, 0);
        pulse_start();
        wait_done(dc, fc);
        chk("R7 R8 restarted run length", dc, 5 * N * 3);
        chk("R7 restarted good", good_o, 1);
        check_trace("restart");
    endtask

    initial begin
        t_reset_clean();
        t_stuck_bit();
        t_bridge();
        t_alias();
        t_latency_spur();
        t_restart_midrun();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule